// File: doc/BRIEF.md
# Parallel-Port FIFO Service Request Controller

This block sits between the 16-byte data FIFO of an extended-capability parallel port and the host. It does not store any data. It watches the FIFO fill level, the transfer direction and a small control word. From these it decides when the host should be asked to move bytes. It can ask in two ways: by a DMA request, or by an interrupt for interrupt-driven programmed I/O. It supports both directions: FIFO-to-host (reverse) and host-to-FIFO (forward).

**DMA mode.** The request follows the FIFO level.
- A request stops for one of two reasons: the FIFO runs out (empty, or full when writing), or a terminal-count cycle ends the transfer.
- Each reason has its own restart rule.
- A run of acknowledged DMA cycles is cut after a fixed maximum, so that other bus traffic is not held off.
- A terminal count also raises a request to set the service-interrupt bit in the register file. The block raises an interrupt at the same time.

**Programmed I/O mode.** The block compares the FIFO occupancy (reverse) or free space (forward) with a programmed threshold. The threshold field holds the threshold minus one, and its top code is clamped.

Top module: `ppsvc_ctrl`

## Requirements
- R1: After reset, `dma_req`, `svc_set` and `svc_irq` are all 0.
- R2: A threshold field value n gives a threshold of n+1. The field value 15 gives a threshold of 15, not 16. In programmed I/O with `cfg_to_host`=1, the interrupt is high exactly while `fifo_level` is at or above the threshold.
- R3: In programmed I/O with `cfg_to_host`=0, the interrupt is high exactly while the free space (16 − `fifo_level`) is at or above the threshold.
- R4: The programmed I/O interrupt is raised only while `cfg_dma_en`=0 and `cfg_svc_intr`=0. It follows its inputs in the same cycle.
- R5: `dma_req` is a registered output. It is high in a cycle only if, at the previous clock edge, `cfg_dma_en`=1 and `cfg_svc_intr`=0 and no terminal count was pending.
- R6: With `cfg_to_host`=1, the request is high while the FIFO holds at least one byte. It drops one cycle after the level reaches 0, and returns one cycle after a byte is present again.
- R7: With `cfg_to_host`=0, the request is high while `fifo_level` is below 16, and drops one cycle after the level reaches 16.
- R8: An acknowledged cycle with `dma_tc`=1 has three effects on the next cycle: `dma_req` goes low, `svc_set` goes high, and `svc_irq` goes high.
- R9: After a terminal count, no request is made until `cfg_svc_intr` has been seen at 1, then 0, with data present. `svc_set` stays high until `cfg_svc_intr`=1 is seen.
- R10: No more than 32 consecutive acknowledged cycles occur in one request. After the 32nd, `dma_req` is low for exactly one cycle, then it returns if the conditions still hold.
- R11: The interrupt raised by a terminal count stays high until `cfg_svc_intr` changes from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dma_en | input | 1 | DMA enable bit from the control register |
| cfg_svc_intr | input | 1 | Service-interrupt bit; when 1, DMA is blocked |
| cfg_to_host | input | 1 | 1 = FIFO-to-host, 0 = host-to-FIFO |
| cfg_thr | input | 4 | Threshold minus one |
| fifo_level | input | 5 | Number of bytes in the FIFO, 0 to 16 |
| dma_req | output | 1 | DMA request to the host |
| dma_ack | input | 1 | One DMA cycle is served this clock |
| dma_tc | input | 1 | Terminal count, valid together with `dma_ack` |
| svc_set | output | 1 | Asks the register file to set the service-interrupt bit |
| svc_irq | output | 1 | Interrupt to the host |

## Verification
The checker watches five things on every cycle:
- the length of each acknowledged run and the forced release after 32 cycles;
- that a request never rises while DMA is disabled;
- that a request never rises while the FIFO is empty (reverse) or full (forward);
- the one-cycle reaction to a terminal count.

Some behaviours only the bench scenarios can show. These are the threshold arithmetic, including the clamped top code, and the forward free-space comparison. They also include the two-step handshake on the service-interrupt bit needed to restart after a terminal count, and the clearing of the terminal-count interrupt.

// File: rtl/ppsvc_pkg.sv
// Package: shared types for the parallel-port FIFO service controller.
// Assumes: nothing beyond SystemVerilog 2017.
package ppsvc_pkg;

    // Transfer direction as seen from the FIFO.
    typedef enum logic {
        DIR_TO_FIFO = 1'b0,
        DIR_TO_HOST = 1'b1
    } xfer_dir_e;

endpackage

// File: rtl/ppsvc_thr_cmp.sv
// Module: turns the threshold field into a threshold and compares it
// with the occupancy (to host) or the free space (to FIFO).
// Assumes: fifo_level never exceeds DEPTH.
module ppsvc_thr_cmp
    import ppsvc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int THR_W = $clog2(DEPTH)
) (
    input  logic [THR_W-1:0] thr_field,
    input  xfer_dir_e        dir,
    input  logic [LVL_W-1:0] fifo_level,
    output logic             at_thr
);

    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    logic [LVL_W-1:0] thr_eff;
    logic [LVL_W-1:0] measure;

    // Field + 1, except that the top code is clamped to DEPTH-1.
    always_comb begin
        if (thr_field == THR_W'(DEPTH - 1))
            thr_eff = LVL_W'(DEPTH - 1);
        else
            thr_eff = LVL_W'(thr_field) + LVL_W'(1);
    end

    // Pick the quantity that the direction makes relevant, then compare.
    always_comb begin
        measure = (dir == DIR_TO_HOST) ? fifo_level : (FULL - fifo_level);
        at_thr  = (measure >= thr_eff);
    end

endmodule

// File: rtl/ppsvc_dma_req.sv
// Module: generates the DMA request. It limits the burst length, stops
// the request at terminal count, and holds a pending flag until the
// service-interrupt bit is seen set.
// Assumes: dma_tc is only meaningful together with dma_ack, and
// fifo_level reflects each served cycle by the next clock.
module ppsvc_dma_req
    import ppsvc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BURST_MAX = 32,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int CNT_W = $clog2(BURST_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_en,
    input  logic             svc_intr,
    input  xfer_dir_e        dir,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             dma_ack,
    input  logic             dma_tc,
    output logic             dma_req,
    output logic             tc_pend,
    output logic             tc_evt
);

    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_MAX - 1);

    logic             req_q;
    logic             pend_q;
    logic [CNT_W-1:0] run_q;
    logic             data_ok;
    logic             want;
    logic             served;

    // Data is available to move in the selected direction.
    always_comb begin
        data_ok = (dir == DIR_TO_HOST) ? (fifo_level != '0) : (fifo_level != FULL);
        want    = dma_en & ~svc_intr & ~pend_q & data_ok;
        served  = req_q & dma_ack;
        tc_evt  = served & dma_tc;
    end

    // Request register and length of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            run_q <= '0;
        end else if (tc_evt || (served && run_q == LAST)) begin
            req_q <= 1'b0;
            run_q <= '0;
        end else begin
            req_q <= want;
            if (!want)
                run_q <= '0;
            else if (served)
                run_q <= run_q + CNT_W'(1);
        end
    end

    // Terminal-count pending flag, cleared once the register shows it set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (tc_evt)
            pend_q <= 1'b1;
        else if (svc_intr)
            pend_q <= 1'b0;
    end

    assign dma_req = req_q;
    assign tc_pend = pend_q;

endmodule

// File: rtl/ppsvc_irq.sv
// Module: the interrupt. It combines the programmed I/O threshold
// interrupt with a latched terminal-count interrupt.
// Assumes: tc_evt is a single-cycle pulse.
module ppsvc_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_en,
    input  logic svc_intr,
    input  logic at_thr,
    input  logic tc_evt,
    output logic irq
);

    logic svc_q;
    logic tc_irq_q;
    logic pio_irq;

    // Keep the previous service-interrupt bit to detect when it is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)
            svc_q <= 1'b0;
        else
            svc_q <= svc_intr;
    end

    // Terminal-count interrupt: set on the event, cleared when the bit goes 1 -> 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tc_irq_q <= 1'b0;
        else if (tc_evt)
            tc_irq_q <= 1'b1;
        else if (svc_q && !svc_intr)
            tc_irq_q <= 1'b0;
    end

    // Programmed I/O interrupt, only while both control bits are clear.
    always_comb begin
        pio_irq = ~dma_en & ~svc_intr & at_thr;
        irq     = pio_irq | tc_irq_q;
    end

endmodule

// File: rtl/ppsvc_ctrl.sv
// Module: top of the parallel-port FIFO service request controller.
// It chooses between a DMA request and an interrupt to get the host
// to move FIFO data.
// Assumes: the register file sets its service-interrupt bit while
// svc_set is high.
module ppsvc_ctrl
    import ppsvc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BURST_MAX = 32,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int THR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_dma_en,
    input  logic             cfg_svc_intr,
    input  logic             cfg_to_host,
    input  logic [THR_W-1:0] cfg_thr,
    input  logic [LVL_W-1:0] fifo_level,
    output logic             dma_req,
    input  logic             dma_ack,
    input  logic             dma_tc,
    output logic             svc_set,
    output logic             svc_irq
);

    xfer_dir_e dir;
    logic      at_thr;
    logic      tc_evt;

    // Map the direction bit onto the shared enum.
    assign dir = xfer_dir_e'(cfg_to_host);

    ppsvc_thr_cmp #(.DEPTH(DEPTH)) u_thr (
        .thr_field (cfg_thr),
        .dir       (dir),
        .fifo_level(fifo_level),
        .at_thr    (at_thr)
    );

    ppsvc_dma_req #(.DEPTH(DEPTH), .BURST_MAX(BURST_MAX)) u_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .dma_en    (cfg_dma_en),
        .svc_intr  (cfg_svc_intr),
        .dir       (dir),
        .fifo_level(fifo_level),
        .dma_ack   (dma_ack),
        .dma_tc    (dma_tc),
        .dma_req   (dma_req),
        .tc_pend   (svc_set),
        .tc_evt    (tc_evt)
    );

    ppsvc_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .dma_en  (cfg_dma_en),
        .svc_intr(cfg_svc_intr),
        .at_thr  (at_thr),
        .tc_evt  (tc_evt),
        .irq     (svc_irq)
    );

endmodule

// File: rtl/ppsvc_ctrl_chk.sv
// Module: checker for ppsvc_ctrl, attached with bind. It counts the
// acknowledged run itself, so the burst window is not unrolled.
// Assumes: the same parameters as the bound instance.
module ppsvc_ctrl_chk #(
    parameter int DEPTH = 16,
    parameter int BURST_MAX = 32,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int CNT_W = $clog2(BURST_MAX + 2)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_dma_en,
    input logic             cfg_svc_intr,
    input logic             cfg_to_host,
    input logic [LVL_W-1:0] fifo_level,
    input logic             dma_req,
    input logic             dma_ack,
    input logic             dma_tc,
    input logic             svc_set,
    input logic             svc_irq
);

    logic [CNT_W-1:0] run_cnt;

    // Independent count of acknowledged cycles while the request is high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_cnt <= '0;
        else if (!dma_req)
            run_cnt <= '0;
        else if (dma_ack)
            run_cnt <= run_cnt + CNT_W'(1);
    end

    AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CNT_W'(BURST_MAX)); // R10
    AST_BURST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt == CNT_W'(BURST_MAX) |-> !dma_req); // R10
    AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> $past(cfg_dma_en && !cfg_svc_intr)); // R5
    AST_REQ_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) && $past(cfg_to_host) |-> $past(fifo_level) != '0); // R6
    AST_REQ_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) && !$past(cfg_to_host) |-> $past(fifo_level) != LVL_W'(DEPTH)); // R7
    AST_TC_REACTION: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && dma_ack && dma_tc |=> !dma_req && svc_set && svc_irq); // R8

endmodule

bind ppsvc_ctrl ppsvc_ctrl_chk #(.DEPTH(DEPTH), .BURST_MAX(BURST_MAX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_dma_en  (cfg_dma_en),
    .cfg_svc_intr(cfg_svc_intr),
    .cfg_to_host (cfg_to_host),
    .fifo_level  (fifo_level),
    .dma_req     (dma_req),
    .dma_ack     (dma_ack),
    .dma_tc      (dma_tc),
    .svc_set     (svc_set),
    .svc_irq     (svc_irq)
);

// File: tb/ppsvc_ctrl_tb.sv
module ppsvc_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_dma_en = 1'b0;
    logic       cfg_svc_intr = 1'b0;
    logic       cfg_to_host = 1'b1;
    logic [3:0] cfg_thr = 4'd0;
    logic [4:0] fifo_level = 5'd0;
    logic       dma_req;
    logic       dma_ack = 1'b0;
    logic       dma_tc = 1'b0;
    logic       svc_set;
    logic       svc_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ppsvc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_dma_en(cfg_dma_en), .cfg_svc_intr(cfg_svc_intr),
        .cfg_to_host(cfg_to_host), .cfg_thr(cfg_thr), .fifo_level(fifo_level),
        .dma_req(dma_req), .dma_ack(dma_ack), .dma_tc(dma_tc),
        .svc_set(svc_set), .svc_irq(svc_irq)
    );

    // Programmed I/O vectors: {to_host, dma_en, svc_intr, thr[3:0], level[4:0], expected irq}
    localparam int NV = 14;
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 4'd3,  5'd4,  1'b1},   // R2 threshold 4, level 4
        {1'b1, 1'b0, 1'b0, 4'd3,  5'd3,  1'b0},   // R2 just below
        {1'b1, 1'b0, 1'b0, 4'd15, 5'd15, 1'b1},   // R2 clamped code reaches at 15
        {1'b1, 1'b0, 1'b0, 4'd15, 5'd14, 1'b0},   // R2
        {1'b1, 1'b0, 1'b0, 4'd14, 5'd15, 1'b1},   // R2 threshold 15
        {1'b1, 1'b0, 1'b0, 4'd0,  5'd1,  1'b1},   // R2 threshold 1
        {1'b1, 1'b0, 1'b0, 4'd0,  5'd0,  1'b0},   // R2 empty
        {1'b1, 1'b1, 1'b0, 4'd0,  5'd5,  1'b0},   // R4 DMA enabled
        {1'b1, 1'b0, 1'b1, 4'd0,  5'd5,  1'b0},   // R4 service bit set
        {1'b0, 1'b0, 1'b0, 4'd3,  5'd12, 1'b1},   // R3 free 4, threshold 4
        {1'b0, 1'b0, 1'b0, 4'd3,  5'd13, 1'b0},   // R3 free 3
        {1'b0, 1'b0, 1'b0, 4'd15, 5'd1,  1'b1},   // R3 free 15, clamped
        {1'b0, 1'b0, 1'b0, 4'd15, 5'd2,  1'b0},   // R3 free 14
        {1'b0, 1'b0, 1'b0, 4'd0,  5'd16, 1'b0}    // R3 full
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Advance one clock and settle after the edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk("R1 req", dma_req, 1'b0);
        chk("R1 set", svc_set, 1'b0);
        chk("R1 irq", svc_irq, 1'b0);
        rst_n = 1'b1;
        tick();

        // Programmed I/O table
        for (int i = 0; i < NV; i++) begin
            {cfg_to_host, cfg_dma_en, cfg_svc_intr, cfg_thr, fifo_level} = VEC[i][12:1];
            #1;
            chk($sformatf("R2/R3/R4 vec %0d", i), svc_irq, VEC[i][0]);
            tick();
        end

        // DMA, FIFO to host
        cfg_to_host = 1'b1; cfg_svc_intr = 1'b0; cfg_dma_en = 1'b1; fifo_level = 5'd3;
        tick();
        chk("R5 R6 req with data", dma_req, 1'b1);
        fifo_level = 5'd0;
        tick();
        chk("R6 drop at empty", dma_req, 1'b0);
        fifo_level = 5'd1;
        tick();
        chk("R6 resume one byte", dma_req, 1'b1);
        cfg_dma_en = 1'b0;
        tick();
        chk("R5 disabled", dma_req, 1'b0);
        cfg_dma_en = 1'b1;
        tick();
        chk("R5 re-enabled", dma_req, 1'b1);

        // Burst limit
        fifo_level = 5'd5; dma_ack = 1'b1;
        for (int k = 0; k < 32; k++) begin
            chk($sformatf("R10 held cycle %0d", k), dma_req, 1'b1);
            tick();
        end
        chk("R10 released", dma_req, 1'b0);
        tick();
        chk("R10 reasserted", dma_req, 1'b1);
        dma_ack = 1'b0;
        tick();

        // Terminal count
        dma_ack = 1'b1; dma_tc = 1'b1;
        tick();
        dma_ack = 1'b0; dma_tc = 1'b0;
        chk("R8 req low", dma_req, 1'b0);
        chk("R8 svc_set", svc_set, 1'b1);
        chk("R8 irq", svc_irq, 1'b1);
        tick();
        chk("R9 no restart", dma_req, 1'b0);
        chk("R9 svc_set held", svc_set, 1'b1);
        cfg_svc_intr = 1'b1;
        tick();
        chk("R9 svc_set cleared", svc_set, 1'b0);
        chk("R9 still blocked", dma_req, 1'b0);
        chk("R11 irq held", svc_irq, 1'b1);
        cfg_svc_intr = 1'b0;
        tick();
        chk("R11 irq cleared", svc_irq, 1'b0);
        chk("R9 restarted", dma_req, 1'b1);

        // DMA, host to FIFO
        cfg_to_host = 1'b0; fifo_level = 5'd15;
        tick();
        chk("R7 req not full", dma_req, 1'b1);
        fifo_level = 5'd16;
        tick();
        chk("R7 drop at full", dma_req, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule